// File: doc/BRIEF.md
# Memory FIFO Self-Test Engine

This block drives pattern traffic into a memory-backed packet FIFO and checks what comes back. A start strobe captures a byte count, a pattern choice and a continuous-mode flag. The transmit side then streams pattern words toward the FIFO input, one word per accepted handshake. The receive side takes words from the FIFO output and compares each one against the same pattern, which it regenerates locally.

Four 64-bit counters report the run: bytes sent, bytes received, mismatched words, and clock cycles spent running. A running flag shows whether a test is in progress. Dividing the byte count by the cycle count gives the throughput. A stop strobe ends any test at once and zeroes every counter, so software issues it before a new measured run. In continuous mode the pattern restarts after each pass of the programmed length, and the test runs until it is stopped.

Top module: `mfifo_bist`

## Requirements
- R1: When `start_i` is high at a clock edge, `running_o` rises after that edge, provided the block is idle, `byte_count_i` is nonzero and `stop_i` is low. At that same edge the block captures `byte_count_i`, `pattern_i` and `continuous_i`. A start strobe while running, or with a zero byte count, is ignored.
- R2: `stop_i` has priority over `start_i`. After the edge where `stop_i` is high, `running_o` is low, `tx_valid_o` is low, and all four counters read zero.
- R3: In a finite run, `running_o` falls right after the edge where the receive side accepts the last word. `tx_valid_o` is never high while `running_o` is low.
- R4: A finite run of N bytes advances the transmit and receive byte counters by exactly N each. When N is not a multiple of the word size, the last word adds only N mod (DATA_W/8) bytes.
- R5: The error counter adds one for every received word that differs from the expected pattern word. A clean run leaves it unchanged.
- R6: The cycle counter adds one at every clock edge where `running_o` is high. With the FIFO always ready and a one-cycle loopback, a run of W words counts W+1 cycles.
- R7: The pattern codes give word k as follows. Code 0: all zeros for even k, all ones for odd k. Code 1: 0xAA..AA for even k, 0x55..55 for odd k. Code 2: the value k. Code 3: the bitwise inverse of k.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds steady. `rx_ready_o` is always high.
- R9: In continuous mode, the word index goes back to 0 after ceil(N/(DATA_W/8)) words, on both the transmit and receive sides. The test runs and the counters grow until a stop strobe.
- R10: Words presented on the receive port while not running change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop and counter-clear strobe |
| continuous_i | input | 1 | Continuous mode, sampled with start |
| pattern_i | input | 2 | Pattern code, sampled with start |
| byte_count_i | input | CNT_W | Bytes per run or per pass, sampled with start |
| tx_data_o | output | DATA_W | Word toward FIFO input |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | FIFO input ready |
| rx_data_i | input | DATA_W | Word from FIFO output |
| rx_valid_i | input | 1 | Receive word valid |
| rx_ready_o | output | 1 | Always-high receive ready |
| tx_bytes_o | output | CNT_W | Bytes sent |
| rx_bytes_o | output | CNT_W | Bytes received |
| err_count_o | output | CNT_W | Mismatched words |
| cycle_count_o | output | CNT_W | Cycles spent running |
| running_o | output | 1 | Test in progress |

## Verification
The assertions check the per-cycle rules on every cycle: the transmit word holding steady under backpressure, the clearing effect of stop, the cycle counter stepping by one while running, no transmit activity while idle, the received byte count never passing the sent count, and idle receive words being ignored. Some results only the bench scenarios can show. These are the exact pattern values for each code, the partial-word byte total, the error count after a corrupted word, the wrap of the pattern in continuous mode, and the exact cycle count of an unstalled run.

// File: rtl/mfifo_bist_pkg.sv
// Package: shared types for the memory FIFO self-test engine.
// Holds the pattern code enumeration that the generators on both sides decode.
package mfifo_bist_pkg;
    typedef enum logic [1:0] {
        PAT_ZERO_ONE  = 2'd0,
        PAT_CHECKER   = 2'd1,
        PAT_COUNT     = 2'd2,
        PAT_COUNT_INV = 2'd3
    } pat_e;
endpackage

// File: rtl/mfifo_bist_pattern.sv
// Module: mfifo_bist_pattern
// Combinational pattern word generator. Maps a word index and a pattern code
// to a data word. Assumes DATA_W is even. The index is zero-extended or
// truncated to DATA_W for the counting patterns.
module mfifo_bist_pattern
    import mfifo_bist_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 64
) (
    input  pat_e              pat_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] word_o
);
    localparam logic [DATA_W-1:0] ALT_HI = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] ALT_LO = {(DATA_W/2){2'b01}};

    logic [DATA_W-1:0] idx_word;

    // Fit the index to the data width
    generate
        if (DATA_W > IDX_W) begin : g_ext
            assign idx_word = {{(DATA_W-IDX_W){1'b0}}, idx_i};
        end else begin : g_trunc
            assign idx_word = idx_i[DATA_W-1:0];
        end
    endgenerate

    // Select the word for the chosen pattern
    always_comb begin
        unique case (pat_i)
            PAT_ZERO_ONE:  word_o = idx_i[0] ? '1 : '0;
            PAT_CHECKER:   word_o = idx_i[0] ? ALT_LO : ALT_HI;
            PAT_COUNT:     word_o = idx_word;
            default:       word_o = ~idx_word;
        endcase
    end
endmodule

// File: rtl/mfifo_bist_tx.sv
// Module: mfifo_bist_tx
// Transmit generator. After launch it streams pattern words under ready/valid
// flow control and counts the bytes sent. The last word of a pass counts
// last_bytes_i. Configuration inputs are stable from the cycle after launch.
module mfifo_bist_tx
    import mfifo_bist_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 64,
    parameter int LB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              launch_i,
    input  logic              cont_i,
    input  pat_e              pat_i,
    input  logic [CNT_W-1:0]  words_i,
    input  logic [LB_W-1:0]   last_bytes_i,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  bytes_o
);
    localparam int BPW = DATA_W / 8;

    logic             active_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] bytes_q;
    logic             fire;
    logic             last_word;
    logic [CNT_W-1:0] add_bytes;

    mfifo_bist_pattern #(.DATA_W(DATA_W), .IDX_W(CNT_W)) u_pat (
        .pat_i  (pat_i),
        .idx_i  (idx_q),
        .word_o (data_o)
    );

    // Handshake and last-word decode
    always_comb begin
        fire      = active_q && ready_i;
        last_word = (idx_q == words_i - 1'b1);
        add_bytes = last_word ? CNT_W'(last_bytes_i) : CNT_W'(BPW);
    end

    // Word index, active flag and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            bytes_q  <= '0;
        end else if (launch_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (fire) begin
            bytes_q <= bytes_q + add_bytes;
            if (last_word) begin
                idx_q <= '0;
                if (!cont_i) active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign valid_o = active_q;
    assign bytes_o = bytes_q;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !clear_i) |=> (valid_o && $stable(data_o))); // R8
endmodule

// File: rtl/mfifo_bist_rx.sv
// Module: mfifo_bist_rx
// Receive checker. While run_i is high it accepts every presented word,
// compares it with the regenerated pattern, and counts bytes and mismatches.
// It raises done_o on the final word of a finite run.
module mfifo_bist_rx
    import mfifo_bist_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 64,
    parameter int LB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              launch_i,
    input  logic              run_i,
    input  logic              cont_i,
    input  pat_e              pat_i,
    input  logic [CNT_W-1:0]  words_i,
    input  logic [LB_W-1:0]   last_bytes_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CNT_W-1:0]  bytes_o,
    output logic [CNT_W-1:0]  errs_o,
    output logic              done_o
);
    localparam int BPW = DATA_W / 8;

    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  bytes_q;
    logic [CNT_W-1:0]  errs_q;
    logic [DATA_W-1:0] expect_word;
    logic              fire;
    logic              last_word;
    logic              mismatch;
    logic [CNT_W-1:0]  add_bytes;

    mfifo_bist_pattern #(.DATA_W(DATA_W), .IDX_W(CNT_W)) u_pat (
        .pat_i  (pat_i),
        .idx_i  (idx_q),
        .word_o (expect_word)
    );

    // Accept, compare and last-word decode
    always_comb begin
        fire      = run_i && valid_i;
        last_word = (idx_q == words_i - 1'b1);
        mismatch  = (data_i != expect_word);
        add_bytes = last_word ? CNT_W'(last_bytes_i) : CNT_W'(BPW);
        done_o    = fire && last_word && !cont_i;
    end

    // Expected index, byte counter and error counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q   <= '0;
            bytes_q <= '0;
            errs_q  <= '0;
        end else if (launch_i) begin
            idx_q <= '0;
        end else if (fire) begin
            bytes_q <= bytes_q + add_bytes;
            if (mismatch) errs_q <= errs_q + 1'b1;
            idx_q <= last_word ? '0 : idx_q + 1'b1;
        end
    end

    assign bytes_o = bytes_q;
    assign errs_o  = errs_q;

    AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> ($stable(bytes_o) && $stable(errs_o))); // R10
endmodule

// File: rtl/mfifo_bist.sv
// Module: mfifo_bist (top)
// Self-test engine for a memory-backed FIFO. Captures the run configuration
// on start, owns the running flag and the cycle counter, and ties together
// the transmit generator and the receive checker. Assumes DATA_W is a
// power-of-two multiple of 8, at least 16.
module mfifo_bist
    import mfifo_bist_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              continuous_i,
    input  logic [1:0]        pattern_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    output logic [CNT_W-1:0]  tx_bytes_o,
    output logic [CNT_W-1:0]  rx_bytes_o,
    output logic [CNT_W-1:0]  err_count_o,
    output logic [CNT_W-1:0]  cycle_count_o,
    output logic              running_o
);
    localparam int BPW     = DATA_W / 8;
    localparam int LOG_BPW = $clog2(BPW);
    localparam int LB_W    = LOG_BPW + 1;

    logic             running_q;
    logic [CNT_W-1:0] cyc_q;
    logic             cfg_cont_q;
    pat_e             cfg_pat_q;
    logic [CNT_W-1:0] cfg_words_q;
    logic [LB_W-1:0]  cfg_last_q;
    logic             launch;
    logic             rx_done;
    logic [LOG_BPW-1:0] tail;
    logic [CNT_W-1:0] words_calc;
    logic [LB_W-1:0]  last_calc;

    // Start qualification and run-length arithmetic
    always_comb begin
        launch     = start_i && !stop_i && !running_q && (byte_count_i != '0);
        tail       = byte_count_i[LOG_BPW-1:0];
        words_calc = (byte_count_i >> LOG_BPW) + CNT_W'(tail != '0);
        last_calc  = (tail == '0) ? LB_W'(BPW) : LB_W'(tail);
    end

    // Configuration capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_cont_q  <= 1'b0;
            cfg_pat_q   <= PAT_ZERO_ONE;
            cfg_words_q <= '0;
            cfg_last_q  <= '0;
        end else if (launch) begin
            cfg_cont_q  <= continuous_i;
            cfg_pat_q   <= pat_e'(pattern_i);
            cfg_words_q <= words_calc;
            cfg_last_q  <= last_calc;
        end
    end

    // Running flag: stop wins, then start, then finite completion
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i)  running_q <= 1'b0;
        else if (launch)       running_q <= 1'b1;
        else if (rx_done)      running_q <= 1'b0;
    end

    // Cycle counter advancing while a run is in progress
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i)  cyc_q <= '0;
        else if (running_q)    cyc_q <= cyc_q + 1'b1;
    end

    mfifo_bist_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LB_W(LB_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (stop_i),
        .launch_i     (launch),
        .cont_i       (cfg_cont_q),
        .pat_i        (cfg_pat_q),
        .words_i      (cfg_words_q),
        .last_bytes_i (cfg_last_q),
        .valid_o      (tx_valid_o),
        .ready_i      (tx_ready_i),
        .data_o       (tx_data_o),
        .bytes_o      (tx_bytes_o)
    );

    mfifo_bist_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LB_W(LB_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (stop_i),
        .launch_i     (launch),
        .run_i        (running_q),
        .cont_i       (cfg_cont_q),
        .pat_i        (cfg_pat_q),
        .words_i      (cfg_words_q),
        .last_bytes_i (cfg_last_q),
        .valid_i      (rx_valid_i),
        .data_i       (rx_data_i),
        .bytes_o      (rx_bytes_o),
        .errs_o       (err_count_o),
        .done_o       (rx_done)
    );

    assign rx_ready_o    = 1'b1;
    assign running_o     = running_q;
    assign cycle_count_o = cyc_q;

    AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!running_o && !tx_valid_o && tx_bytes_o == '0 && rx_bytes_o == '0
                    && err_count_o == '0 && cycle_count_o == '0)); // R2
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !stop_i) |=> !running_o); // R3
    AST_IDLE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !tx_valid_o); // R3
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !stop_i) |=> (cycle_count_o == $past(cycle_count_o) + 1'b1)); // R6
    AST_RX_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bytes_o <= tx_bytes_o); // R4
endmodule

// File: tb/mfifo_bist_tb_top.sv
module mfifo_bist_tb_top;
    localparam int DW = 64;
    localparam int CW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          continuous_i = 1'b0;
    logic [1:0]    pattern_i = 2'd0;
    logic [CW-1:0] byte_count_i = '0;
    logic [DW-1:0] tx_data_o;
    logic          tx_valid_o;
    logic          tx_ready_i = 1'b1;
    logic [DW-1:0] rx_data_i = '0;
    logic          rx_valid_i = 1'b0;
    logic          rx_ready_o;
    logic [CW-1:0] tx_bytes_o, rx_bytes_o, err_count_o, cycle_count_o;
    logic          running_o;

    mfifo_bist #(.DATA_W(DW), .CNT_W(CW)) dut_i (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] fifo_q[$];
    bit  bp_en = 1'b0;
    int  tb_cyc = 0;
    int  pop_idx = 0;
    int  corrupt_at = -1;
    int  inj_n = 0;

    function automatic logic [DW-1:0] pat_word(int p, longint unsigned k);
        case (p)
            0: return k[0] ? {DW{1'b1}} : {DW{1'b0}};
            1: return k[0] ? {(DW/4){4'h5}} : {(DW/4){4'hA}};
            2: return DW'(k);
            default: return ~DW'(k);
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FIFO-BIST FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // FIFO model plus scoreboard monitor, all at the falling edge
    always @(negedge clk) begin
        tb_cyc++;
        tx_ready_i = bp_en ? ((tb_cyc % 3) != 2) : 1'b1;
        if (inj_n > 0) begin
            rx_valid_i = 1'b1;
            rx_data_i  = 64'hDEAD_BEEF_0000_0001;
            inj_n--;
        end else if (fifo_q.size() > 0) begin
            rx_data_i  = fifo_q.pop_front();
            if (pop_idx == corrupt_at) rx_data_i = rx_data_i ^ 64'h1;
            pop_idx++;
            rx_valid_i = 1'b1;
        end else begin
            rx_valid_i = 1'b0;
        end
        if (tx_valid_o && tx_ready_i) begin
            fifo_q.push_back(tx_data_o);
            if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected tx word", tx_data_o, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(tx_data_o == e, "R7", "tx pattern word", tx_data_o, e);
            end
        end
    end

    // Driver: queue expected words, then pulse start
    task automatic run_start(int p, longint unsigned n, bit cont, int passes);
        longint unsigned w;
        w = (n + 7) / 8;
        for (int ps = 0; ps < passes; ps++)
            for (longint unsigned k = 0; k < w; k++) exp_q.push_back(pat_word(p, k));
        pop_idx = 0;
        @(negedge clk);
        start_i = 1'b1; pattern_i = 2'(p); byte_count_i = n; continuous_i = cont;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        exp_q.delete();
        fifo_q.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (!running_o) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic finite_run(int p, longint unsigned n, string req);
        run_start(p, n, 1'b0, 1);
        wait_done();
        chk(!running_o, "R3", "running after finite run", 64'(running_o), 0);
        chk(tx_bytes_o == n, req, "tx bytes", tx_bytes_o, n);
        chk(rx_bytes_o == n, req, "rx bytes", rx_bytes_o, n);
        chk(err_count_o == 0, "R5", "errors on clean run", err_count_o, 0);
        chk(exp_q.size() == 0, "R7", "expected words left", 64'(exp_q.size()), 0);
        do_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!running_o && !tx_valid_o, "R2", "reset idle", 64'(running_o), 0);
        chk(tx_bytes_o == 0 && rx_bytes_o == 0 && err_count_o == 0 && cycle_count_o == 0,
            "R2", "reset counters", tx_bytes_o | rx_bytes_o, 0);
        chk(rx_ready_o == 1'b1, "R8", "rx ready", 64'(rx_ready_o), 1);

        // Unstalled count run: 8 words, exact cycle count
        run_start(2, 64, 1'b0, 1);
        chk(running_o, "R1", "running after start", 64'(running_o), 1);
        wait_done();
        chk(cycle_count_o == 9, "R6", "cycle count 8 words", cycle_count_o, 9);
        chk(tx_bytes_o == 64 && rx_bytes_o == 64, "R4", "bytes 64", rx_bytes_o, 64);
        chk(err_count_o == 0, "R5", "clean errors", err_count_o, 0);
        do_stop();
        chk(tx_bytes_o == 0 && rx_bytes_o == 0 && cycle_count_o == 0, "R2",
            "counters after stop", cycle_count_o, 0);

        // Other patterns under backpressure
        bp_en = 1'b1;
        finite_run(0, 40, "R8");
        finite_run(1, 40, "R8");
        finite_run(3, 40, "R8");
        bp_en = 1'b0;

        // Partial final word
        finite_run(2, 21, "R4");

        // Corrupted word
        corrupt_at = 1;
        run_start(2, 32, 1'b0, 1);
        wait_done();
        chk(err_count_o == 1, "R5", "one mismatch", err_count_o, 1);
        chk(rx_bytes_o == 32, "R4", "rx bytes with error", rx_bytes_o, 32);
        corrupt_at = -1;
        do_stop();

        // Zero byte count start is ignored
        @(negedge clk);
        start_i = 1'b1; byte_count_i = 0; continuous_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(!running_o && !tx_valid_o, "R1", "zero-byte start", 64'(running_o), 0);

        // Start while running is ignored
        bp_en = 1'b1;
        run_start(2, 64, 1'b0, 1);
        repeat (2) @(negedge clk);
        start_i = 1'b1; byte_count_i = 8; continuous_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(tx_bytes_o == 64, "R1", "restart ignored tx", tx_bytes_o, 64);
        chk(!running_o, "R1", "restart did not make continuous", 64'(running_o), 0);
        bp_en = 1'b0;
        do_stop();

        // Stop and start together: stop wins
        @(negedge clk);
        start_i = 1'b1; stop_i = 1'b1; byte_count_i = 64; continuous_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk(!running_o && !tx_valid_o, "R2", "stop beats start", 64'(running_o), 0);
        repeat (2) @(negedge clk);

        // Words arriving while idle are ignored
        inj_n = 3;
        repeat (6) @(negedge clk);
        chk(rx_bytes_o == 0, "R10", "idle rx bytes", rx_bytes_o, 0);
        chk(err_count_o == 0, "R10", "idle errors", err_count_o, 0);

        // Continuous run: pattern wraps every 3 words
        run_start(2, 20, 1'b1, 100);
        repeat (60) @(negedge clk);
        chk(running_o, "R9", "still running", 64'(running_o), 1);
        chk(tx_bytes_o > 40, "R9", "tx bytes grow", tx_bytes_o, 41);
        chk(err_count_o == 0, "R9", "wrapped pattern clean", err_count_o, 0);
        do_stop();
        chk(!running_o && cycle_count_o == 0 && tx_bytes_o == 0, "R2",
            "stop ends continuous", cycle_count_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule